// File: doc/BRIEF.md
# Independent Serial Baud Clock Generator

This block produces the bit-rate timing for a serial controller. Its transmit side and its receive side are two separate dividers. Each one raises a one-cycle enable pulse in the bus clock domain once per divided period. The serial datapath uses these pulses to step its shift registers. Each side has its own 4-bit rate code. The code chooses one of three ways to form the period. The first is the bus clock divided by a programmable divisor and then scaled by sixteen. The second is the same divisor scaled by ten. The third ignores the divisor and divides an external master clock by ten.

Both directions share one 16-bit divisor. It is written as two byte registers, one for the high half and one for the low half, each with its own write strobe. The external master clock is asynchronous to the bus clock. It passes through a two-flop synchronizer, and an edge detector turns each rising edge into a single bus-clock event for the counters. A change of code or divisor never cuts the period already in progress short. Each side picks up its new settings only at its own terminal count.

Top module: `serial_rate_gen`

## Requirements
- R1: While reset is asserted both tick outputs are 0. On the first bus clock edge after reset is released, both ticks go high for one cycle. The divisor resets to 0 and the next period follows the rules below.
- R2: Rate codes 0 to 13 (4'b0000 to 4'b1101) give a tick period of 16 x D bus clock cycles, where D is the 16-bit divisor.
- R3: Rate code 15 (4'b1111) gives a tick period of 10 x D bus clock cycles.
- R4: Rate code 14 (4'b1110) gives one tick per 10 rising edges of the external master clock, whatever the divisor. While a side is in this mode, it cannot tick unless a synchronized rising edge was seen in the cycle before.
- R5: A divisor of 0 acts as a divisor of 1.
- R6: `wr_div_hi` loads `wr_data` into divisor bits 15:8 and `wr_div_lo` loads it into bits 7:0, one clock after the strobe. With no strobe, the divisor holds its value.
- R7: A new rate code or divisor does not shorten or stretch the period in progress. It sets the length of the period that starts at the next tick.
- R8: The transmit and receive sides each follow their own rate code. The rate of one side does not depend on the code of the other.
- R9: Every tick is exactly one bus clock cycle wide, and two ticks of one side are never closer than 10 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_mclk | input | 1 | External master clock, asynchronous |
| wr_data | input | 8 | Byte to write into the divisor |
| wr_div_hi | input | 1 | Write strobe for divisor bits 15:8 |
| wr_div_lo | input | 1 | Write strobe for divisor bits 7:0 |
| tx_sel | input | 4 | Transmit rate code |
| rx_sel | input | 4 | Receive rate code |
| tx_tick | output | 1 | Transmit bit-rate enable pulse |
| rx_tick | output | 1 | Receive bit-rate enable pulse |

## Verification
The bench runs every one of the sixteen rate codes against divisors of 0, 1, 2, 5 and 13. The receive side always holds the mirrored code, so each pass checks both sides on different settings. This separates the 16x range from the 10x code and from the external mode, and the zero divisor shows whether it is promoted to 1. Divisors 0x0102 and then 0x0103 show that each byte strobe lands in its own half. The external clock has a period of 7 bus cycles, so a 70-cycle period tells the external mode apart from any divisor result. Changing the code and the divisor partway through a period shows whether the running period is cut short or takes the new value early.

// File: rtl/serial_rate_pkg.sv
package serial_rate_pkg;

   typedef enum logic [1:0] {
      RM_WIDE   = 2'd0,   // divisor scaled by the wide factor
      RM_NARROW = 2'd1,   // divisor scaled by the narrow factor
      RM_EXT    = 2'd2    // external master clock, fixed division
   } rate_mode_e;

   localparam logic [3:0] CODE_EXT    = 4'b1110;
   localparam logic [3:0] CODE_NARROW = 4'b1111;

   function automatic rate_mode_e decode_code(input logic [3:0] code);
      if (code == CODE_EXT)         return RM_EXT;
      else if (code == CODE_NARROW) return RM_NARROW;
      else                          return RM_WIDE;
   endfunction

endpackage

// File: rtl/srg_edge_sync.sv
module srg_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("srg_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   // STAGES synchronizer flops plus one history flop for the edge detector
   logic [STAGES:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-1:0], async_in};
   end

   assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/srg_div_reg.sv
module srg_div_reg #(
   parameter int BYTE_W = 8,
   parameter int NBYTES = 2,
   localparam int DIV_W = BYTE_W * NBYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [NBYTES-1:0] wr_byte,
   output logic [DIV_W-1:0]  div_o
);
   generate
      if (BYTE_W < 1 || NBYTES < 1) begin : g_bad_shape
         $error("srg_div_reg: BYTE_W and NBYTES must be positive");
      end
   endgenerate

   logic [BYTE_W-1:0] byte_q [NBYTES];

   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          byte_q[b] <= '0;
         else if (wr_byte[b]) byte_q[b] <= wr_data;
      end
      assign div_o[b*BYTE_W +: BYTE_W] = byte_q[b];
   end

endmodule

// File: rtl/srg_channel.sv
module srg_channel
   import serial_rate_pkg::*;
#(
   parameter int DIV_W        = 16,
   parameter int CNT_W        = 20,
   parameter int WIDE_SCALE   = 16,
   parameter int NARROW_SCALE = 10,
   parameter int EXT_DIV      = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       code,
   input  logic [DIV_W-1:0] divisor,
   input  logic             ext_rise,
   output logic             tick_o,
   output logic             ext_active_o
);
   generate
      if (CNT_W < DIV_W + $clog2(WIDE_SCALE) || CNT_W < DIV_W + $clog2(NARROW_SCALE)) begin : g_bad_cnt
         $error("srg_channel: CNT_W too narrow for the scaled divisor");
      end
      if (EXT_DIV < 2 || EXT_DIV > (1 << CNT_W)) begin : g_bad_ext
         $error("srg_channel: EXT_DIV out of range");
      end
   endgenerate

   rate_mode_e       mode;
   logic [CNT_W-1:0] div_eff;
   logic [CNT_W-1:0] reload;
   logic [CNT_W-1:0] cnt_q;
   logic             ext_q;
   logic             tick_q;
   logic             advance;

   assign mode    = decode_code(code);
   assign div_eff = (divisor == '0) ? CNT_W'(1) : CNT_W'(divisor);

   always_comb begin
      unique case (mode)
         RM_WIDE:   reload = div_eff * CNT_W'(WIDE_SCALE) - CNT_W'(1);
         RM_NARROW: reload = div_eff * CNT_W'(NARROW_SCALE) - CNT_W'(1);
         default:   reload = CNT_W'(EXT_DIV - 1);
      endcase
   end

   // the counter steps every bus cycle, or only on external rising edges
   assign advance = ext_q ? ext_rise : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         tick_q <= 1'b0;
         ext_q  <= 1'b0;
      end else begin
         tick_q <= 1'b0;
         if (advance) begin
            if (cnt_q == '0) begin
               // terminal count: settings are sampled only here
               cnt_q  <= reload;
               tick_q <= 1'b1;
               ext_q  <= (mode == RM_EXT);
            end else begin
               cnt_q  <= cnt_q - CNT_W'(1);
            end
         end
      end
   end

   assign tick_o       = tick_q;
   assign ext_active_o = ext_q;

endmodule

// File: rtl/serial_rate_gen.sv
module serial_rate_gen #(
   parameter int BYTE_W       = 8,
   parameter int SYNC_STAGES  = 2,
   parameter int WIDE_SCALE   = 16,
   parameter int NARROW_SCALE = 10,
   parameter int EXT_DIV      = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_mclk,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              wr_div_hi,
   input  logic              wr_div_lo,
   input  logic [3:0]        tx_sel,
   input  logic [3:0]        rx_sel,
   output logic              tx_tick,
   output logic              rx_tick
);
   localparam int DIV_W      = 2 * BYTE_W;
   localparam int SCALE_MAX  = (WIDE_SCALE > NARROW_SCALE) ? WIDE_SCALE : NARROW_SCALE;
   localparam int CNT_W      = DIV_W + $clog2(SCALE_MAX);
   localparam int MIN_SCALE  = (WIDE_SCALE < NARROW_SCALE) ? WIDE_SCALE : NARROW_SCALE;
   localparam int MIN_PERIOD = (MIN_SCALE < EXT_DIV) ? MIN_SCALE : EXT_DIV;
   localparam int NCH        = 2;

   generate
      if (WIDE_SCALE < 2 || NARROW_SCALE < 2) begin : g_bad_scale
         $error("serial_rate_gen: scale factors must be at least 2");
      end
   endgenerate

   logic [DIV_W-1:0] div_q;
   logic             ext_rise;
   logic [3:0]       code_arr [NCH];
   logic [NCH-1:0]   tick_arr;
   logic [NCH-1:0]   ch_ext;

   srg_div_reg #(.BYTE_W(BYTE_W), .NBYTES(2)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_data (wr_data),
      .wr_byte ({wr_div_hi, wr_div_lo}),
      .div_o   (div_q)
   );

   srg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (ext_mclk),
      .rise_o   (ext_rise)
   );

   assign code_arr[0] = tx_sel;
   assign code_arr[1] = rx_sel;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      srg_channel #(
         .DIV_W        (DIV_W),
         .CNT_W        (CNT_W),
         .WIDE_SCALE   (WIDE_SCALE),
         .NARROW_SCALE (NARROW_SCALE),
         .EXT_DIV      (EXT_DIV)
      ) u_ch (
         .clk          (clk),
         .rst_n        (rst_n),
         .code         (code_arr[c]),
         .divisor      (div_q),
         .ext_rise     (ext_rise),
         .tick_o       (tick_arr[c]),
         .ext_active_o (ch_ext[c])
      );
   end

   assign tx_tick = tick_arr[0];
   assign rx_tick = tick_arr[1];

endmodule

// File: rtl/srg_checker.sv
module srg_checker #(
   parameter int BYTE_W  = 8,
   parameter int MIN_GAP = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_tick,
   input logic              rx_tick,
   input logic              ext_rise,
   input logic [1:0]        ch_ext,
   input logic [BYTE_W-1:0] wr_data,
   input logic              wr_div_hi,
   input logic              wr_div_lo,
   input logic [2*BYTE_W-1:0] div_q
);
   logic [15:0] gap_tx, gap_rx;
   logic        seen_tx, seen_rx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_tx  <= '0;
         gap_rx  <= '0;
         seen_tx <= 1'b0;
         seen_rx <= 1'b0;
      end else begin
         if (tx_tick) begin
            gap_tx  <= '0;
            seen_tx <= 1'b1;
         end else if (gap_tx != 16'hFFFF) begin
            gap_tx <= gap_tx + 16'd1;
         end
         if (rx_tick) begin
            gap_rx  <= '0;
            seen_rx <= 1'b1;
         end else if (gap_rx != 16'hFFFF) begin
            gap_rx <= gap_rx + 16'd1;
         end
      end
   end

   a_r6_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_div_lo |=> div_q[BYTE_W-1:0] == $past(wr_data));

   a_r6_hi_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_div_hi |=> div_q[2*BYTE_W-1:BYTE_W] == $past(wr_data));

   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_div_hi && !wr_div_lo) |=> $stable(div_q));

   a_r9_tx_single: assert property (@(posedge clk) disable iff (!rst_n)
      tx_tick |=> !tx_tick);

   a_r9_rx_single: assert property (@(posedge clk) disable iff (!rst_n)
      rx_tick |=> !rx_tick);

   a_r9_tx_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_tick && seen_tx) |-> (gap_tx >= 16'(MIN_GAP - 1)));

   a_r9_rx_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_tick && seen_rx) |-> (gap_rx >= 16'(MIN_GAP - 1)));

   a_r4_tx_waits_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_ext[0] && !ext_rise) |=> !tx_tick);

   a_r4_rx_waits_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_ext[1] && !ext_rise) |=> !rx_tick);

endmodule

bind serial_rate_gen srg_checker #(.BYTE_W(BYTE_W), .MIN_GAP(MIN_PERIOD)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tx_tick   (tx_tick),
   .rx_tick   (rx_tick),
   .ext_rise  (ext_rise),
   .ch_ext    (ch_ext),
   .wr_data   (wr_data),
   .wr_div_hi (wr_div_hi),
   .wr_div_lo (wr_div_lo),
   .div_q     (div_q)
);

// File: tb/sim_serial_rate_gen.sv
module sim_serial_rate_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ext_mclk = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       wr_div_hi = 1'b0;
   logic       wr_div_lo = 1'b0;
   logic [3:0] tx_sel = 4'd0;
   logic [3:0] rx_sel = 4'd0;
   logic       tx_tick, rx_tick;

   int cyc = 0;
   int n_cmp = 0;
   int n_bad = 0;
   localparam int EXT_CYC = 7;   // bus cycles per external clock period

   serial_rate_gen u0 (
      .clk(clk), .rst_n(rst_n), .ext_mclk(ext_mclk), .wr_data(wr_data),
      .wr_div_hi(wr_div_hi), .wr_div_lo(wr_div_lo),
      .tx_sel(tx_sel), .rx_sel(rx_sel), .tx_tick(tx_tick), .rx_tick(rx_tick)
   );

   always #10 clk = ~clk;                       // 50 MHz
   initial begin #5; forever #70 ext_mclk = ~ext_mclk; end

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   always @(posedge clk) begin
      if (cyc == 195000) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog (all requirements): actual=%0d expected<%0d", cyc, 195000);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   function automatic int exp_period(input int code, input int ct);
      int d;
      d = (ct == 0) ? 1 : ct;
      if (code == 14)      return 10 * EXT_CYC;
      else if (code == 15) return 10 * d;
      else                 return 16 * d;
   endfunction

   task automatic wait_tick(input bit use_rx, output int t);
      int guard;
      guard = 0;
      do begin
         @(negedge clk);
         guard++;
      end while (!(use_rx ? rx_tick : tx_tick) && guard < 20000);
      t = cyc;
   endtask

   // waits three ticks so the last interval is wholly under current settings
   task automatic measure(input bit use_rx, output int per);
      int ta, tb, tc;
      wait_tick(use_rx, ta);
      wait_tick(use_rx, tb);
      wait_tick(use_rx, tc);
      per = tc - tb;
      @(negedge clk);
      check("R9 width", int'(use_rx ? rx_tick : tx_tick), 0);
   endtask

   task automatic write_div(input int v);
      @(negedge clk);
      wr_data = v[15:8]; wr_div_hi = 1'b1;
      @(negedge clk);
      wr_div_hi = 1'b0; wr_data = v[7:0]; wr_div_lo = 1'b1;
      @(negedge clk);
      wr_div_lo = 1'b0;
   endtask

   initial begin
      int per, ta, tb, tc, td;
      int cts [5] = '{0, 1, 2, 5, 13};

      // R1: reset state and first tick
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R1 tx in reset", int'(tx_tick), 0);
         check("R1 rx in reset", int'(rx_tick), 0);
      end
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 tx first tick", int'(tx_tick), 1);
      check("R1 rx first tick", int'(rx_tick), 1);
      measure(1'b0, per);
      check("R5 reset divisor zero acts as one", per, 16);

      // R2 R3 R4 R5 R8: sweep codes and divisors, rx holds mirrored code
      foreach (cts[k]) begin
         write_div(cts[k]);
         for (int code = 0; code < 16; code++) begin
            tx_sel = 4'(code);
            rx_sel = 4'(15 - code);
            measure(1'b0, per);
            check(code == 14 ? "R4 tx ext" : (code == 15 ? "R3 tx x10" :
                  (cts[k] == 0 ? "R5 tx zero" : "R2 tx x16")),
                  per, exp_period(code, cts[k]));
            measure(1'b1, per);
            check("R8 rx independent", per, exp_period(15 - code, cts[k]));
         end
      end

      // R6: byte halves of the divisor
      tx_sel = 4'd15;
      write_div(16'h0102);
      measure(1'b0, per);
      check("R6 hi and lo bytes", per, 10 * 258);
      @(negedge clk);
      wr_data = 8'h03; wr_div_lo = 1'b1;
      @(negedge clk);
      wr_div_lo = 1'b0;
      measure(1'b0, per);
      check("R6 lo byte only", per, 10 * 259);

      // R7: changes wait for the terminal count
      write_div(13);
      tx_sel = 4'd0;
      measure(1'b0, per);
      check("R2 settle", per, 208);
      wait_tick(1'b0, ta);
      repeat (5) @(negedge clk);
      tx_sel = 4'd15;
      wait_tick(1'b0, tb);
      check("R7 code change keeps old period", tb - ta, 208);
      wait_tick(1'b0, tc);
      check("R7 code change applies next", tc - tb, 130);
      repeat (3) @(negedge clk);
      write_div(2);
      wait_tick(1'b0, td);
      check("R7 divisor change keeps old period", td - tc, 130);
      wait_tick(1'b0, ta);
      check("R7 divisor change applies next", ta - td, 20);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule